// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block sits beside a two-port shared memory and watches the access strobes of both ports. The two topmost word addresses of the memory serve as mailboxes: the very top word belongs to the right port, and the word just below it belongs to the left port. When one port writes into the other port's mailbox, the owner's interrupt is raised. The interrupt stays raised until the owner reads its own mailbox. The mailbox data itself lives in the surrounding memory; this block only tracks the two interrupt flags.

Each port has a busy input, which the surrounding arbitration drives. While a port's busy input is high, its accesses neither raise the other port's interrupt nor clear its own. All logic is synchronous to one clock. An access is sampled on a rising edge, and the resulting interrupt change is visible after that edge.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After an active-low reset, both `l_irq_n` and `r_irq_n` read 1 (deasserted).
- R2: A left-port write to address 2^ADDR_W-1 (all ones) drives `r_irq_n` to 0 from the cycle after the write edge.
- R3: A right-port write to address 2^ADDR_W-2 drives `l_irq_n` to 0 from the cycle after the write edge.
- R4: A port reading its own mailbox (right: all ones, left: all ones minus one) returns its interrupt output to 1 from the cycle after the read edge.
- R5: A read by a port of the other port's mailbox leaves both interrupts unchanged.
- R6: A write by a port whose busy input is 1 does not raise the other port's interrupt.
- R7: A read by a port whose busy input is 1 does not clear its own interrupt.
- R8: A port writing its own mailbox changes neither interrupt.
- R9: If a raise and a clear of the same interrupt fall in the same cycle, the interrupt ends asserted (0).
- R10: Strobes on a port whose chip enable (`*_en`, active high) is 0 have no effect.
- R11: A cycle with both write and read strobes high on a port counts as a write only, so it cannot clear that port's interrupt.
- R12: Accesses to any address other than the two mailbox words change neither interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_en | input | 1 | Left port chip enable, active high |
| l_wr | input | 1 | Left port write strobe |
| l_rd | input | 1 | Left port read strobe |
| l_addr | input | ADDR_W | Left port word address |
| l_busy | input | 1 | Left port busy from arbitration, active high |
| r_en | input | 1 | Right port chip enable, active high |
| r_wr | input | 1 | Right port write strobe |
| r_rd | input | 1 | Right port read strobe |
| r_addr | input | ADDR_W | Right port word address |
| r_busy | input | 1 | Right port busy from arbitration, active high |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The bench builds the block with ADDR_W = 4. With that width the two mailboxes sit at 15 and 14, and a stream of pseudo-random addresses reaches both of them, often and on both ports in the same cycle. This makes the rarer cases common: busy gating, a raise and a clear colliding on one flag, and a write and a read strobe together on one port. The behavioural model then covers these cases on every clock, in addition to the directed checks.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  localparam int unsigned SIDE_L = 0;
  localparam int unsigned SIDE_R = 1;
  localparam int unsigned N_SIDE = 2;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W  = 15,
  parameter bit          OWN_TOP = 1'b0
) (
  input  logic              en,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic              own_clr,
  output logic              peer_set
);
  localparam logic [ADDR_W-1:0] TOP_A  = '1;
  localparam logic [ADDR_W-1:0] NEXT_A = TOP_A - 1'b1;
  localparam logic [ADDR_W-1:0] OWN_A  = OWN_TOP ? TOP_A : NEXT_A;
  localparam logic [ADDR_W-1:0] PEER_A = OWN_TOP ? NEXT_A : TOP_A;

  acc_e kind;

  // write outranks read when both strobes are high (R11)
  always_comb begin
    if (!en)     kind = ACC_NONE;
    else if (wr) kind = ACC_WRITE;
    else if (rd) kind = ACC_READ;
    else         kind = ACC_NONE;
  end

  assign own_clr  = (kind == ACC_READ)  && (addr == OWN_A)  && !busy;
  assign peer_set = (kind == ACC_WRITE) && (addr == PEER_A) && !busy;

  always_comb begin
    AST_DECODE_EXCL: assert (!(own_clr && peer_set)); // R11
  end
endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (!rst_n)       irq_n <= 1'b1;
    else if (set_req) irq_n <= 1'b0;
    else if (clr_req) irq_n <= 1'b1;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> !irq_n); // R9
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req) |=> irq_n); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_req && !clr_req) |=> $stable(irq_n)); // R12
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy,
  input  logic              r_en,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy,
  output logic              l_irq_n,
  output logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] TOP_A  = '1;
  localparam logic [ADDR_W-1:0] NEXT_A = TOP_A - 1'b1;

  logic              en_v   [N_SIDE];
  logic              wr_v   [N_SIDE];
  logic              rd_v   [N_SIDE];
  logic [ADDR_W-1:0] addr_v [N_SIDE];
  logic              busy_v [N_SIDE];
  logic              clr_v  [N_SIDE];
  logic              set_v  [N_SIDE];
  logic              irq_v  [N_SIDE];

  assign en_v[SIDE_L]   = l_en;
  assign wr_v[SIDE_L]   = l_wr;
  assign rd_v[SIDE_L]   = l_rd;
  assign addr_v[SIDE_L] = l_addr;
  assign busy_v[SIDE_L] = l_busy;
  assign en_v[SIDE_R]   = r_en;
  assign wr_v[SIDE_R]   = r_wr;
  assign rd_v[SIDE_R]   = r_rd;
  assign addr_v[SIDE_R] = r_addr;
  assign busy_v[SIDE_R] = r_busy;

  for (genvar i = 0; i < N_SIDE; i++) begin : g_side
    mbx_port_decode #(
      .ADDR_W (ADDR_W),
      .OWN_TOP(i == SIDE_R)
    ) u_dec (
      .en      (en_v[i]),
      .wr      (wr_v[i]),
      .rd      (rd_v[i]),
      .addr    (addr_v[i]),
      .busy    (busy_v[i]),
      .own_clr (clr_v[i]),
      .peer_set(set_v[i])
    );

    mbx_irq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_req(set_v[N_SIDE-1-i]),
      .clr_req(clr_v[i]),
      .irq_n  (irq_v[i])
    );
  end

  assign l_irq_n = irq_v[SIDE_L];
  assign r_irq_n = irq_v[SIDE_R];

  AST_R_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && l_wr && l_addr == TOP_A && !l_busy) |=> !r_irq_n); // R2
  AST_L_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en && r_wr && r_addr == NEXT_A && !r_busy) |=> !l_irq_n); // R3
  AST_R_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(r_irq_n) |-> $past(l_en && l_wr && l_addr == TOP_A && !l_busy)); // R6
  AST_L_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l_irq_n) |-> $past(r_en && r_wr && r_addr == NEXT_A && !r_busy)); // R6
  AST_R_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_irq_n) |-> $past(r_en && r_rd && !r_wr && r_addr == TOP_A && !r_busy)); // R7
  AST_L_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l_irq_n) |-> $past(l_en && l_rd && !l_wr && l_addr == NEXT_A && !l_busy)); // R7
endmodule

// File: tb/mbx_irq_ctrl_bench.sv
`timescale 1ns/1ps
module mbx_irq_ctrl_bench;
  localparam int unsigned AW = 4;
  localparam int TOPV = (1 << AW) - 1;
  localparam int NXTV = TOPV - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_en = 0, l_wr = 0, l_rd = 0, l_busy = 0;
  logic r_en = 0, r_wr = 0, r_rd = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;

  int tests = 0;
  int fails = 0;
  int ml = 1;
  int mr = 1;
  bit done = 0;

  always #2.5 clk = ~clk;

  mbx_irq_ctrl #(.ADDR_W(AW)) u_mbx_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_busy(l_busy),
    .r_en(r_en), .r_wr(r_wr), .r_rd(r_rd), .r_addr(r_addr), .r_busy(r_busy),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  // behavioural reference: 1 = deasserted, 0 = asserted
  always @(posedge clk) begin
    if (!rst_n) begin
      ml = 1; mr = 1;
    end else begin
      bit sl, sr, cl, cr;
      sr = l_en && l_wr && int'(l_addr) == TOPV && !l_busy;
      sl = r_en && r_wr && int'(r_addr) == NXTV && !r_busy;
      cl = l_en && !l_wr && l_rd && int'(l_addr) == NXTV && !l_busy;
      cr = r_en && !r_wr && r_rd && int'(r_addr) == TOPV && !r_busy;
      if (sl) ml = 0; else if (cl) ml = 1;
      if (sr) mr = 0; else if (cr) mr = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (int'(l_irq_n) != ml || int'(r_irq_n) != mr) begin
        fails++;
        $display("FAIL model(R2,R3,R4,R9) l=%0d r=%0d exp l=%0d r=%0d",
                 l_irq_n, r_irq_n, ml, mr);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic drv(input logic le, lw, lr, input int la, input logic lb,
                     input logic re, rw, rr, input int ra, input logic rb);
    l_en = le; l_wr = lw; l_rd = lr; l_addr = AW'(la); l_busy = lb;
    r_en = re; r_wr = rw; r_rd = rr; r_addr = AW'(ra); r_busy = rb;
    @(posedge clk);
    @(negedge clk);
    l_en = 0; l_wr = 0; l_rd = 0; r_en = 0; r_wr = 0; r_rd = 0;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    chk("R1 l_irq_n in reset", l_irq_n, 1'b1);
    chk("R1 r_irq_n in reset", r_irq_n, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 l_irq_n after reset", l_irq_n, 1'b1);
    chk("R1 r_irq_n after reset", r_irq_n, 1'b1);
    drv(1,1,0,3,0,   1,1,0,5,0);    chk("R12 other addr", r_irq_n, 1'b1);
    chk("R12 other addr left", l_irq_n, 1'b1);
    drv(1,1,0,NXTV,0, 0,0,0,0,0);   chk("R8 own mailbox write", l_irq_n, 1'b1);
    chk("R8 own mailbox write peer", r_irq_n, 1'b1);
    drv(0,1,0,TOPV,0, 0,0,0,0,0);   chk("R10 enable low", r_irq_n, 1'b1);
    drv(1,1,0,TOPV,0, 0,0,0,0,0);   chk("R2 left sets right", r_irq_n, 1'b0);
    drv(1,0,1,TOPV,0, 0,0,0,0,0);   chk("R5 left reads right box", r_irq_n, 1'b0);
    drv(0,0,0,0,0,   1,0,1,TOPV,1); chk("R7 busy read no clear", r_irq_n, 1'b0);
    drv(0,0,0,0,0,   0,0,1,TOPV,0); chk("R10 read enable low", r_irq_n, 1'b0);
    drv(0,0,0,0,0,   1,0,1,TOPV,0); chk("R4 right read clears", r_irq_n, 1'b1);
    drv(1,1,0,TOPV,1, 0,0,0,0,0);   chk("R6 busy write no set", r_irq_n, 1'b1);
    drv(0,0,0,0,0,   1,1,0,NXTV,0); chk("R3 right sets left", l_irq_n, 1'b0);
    drv(1,1,1,NXTV,0, 0,0,0,0,0);   chk("R11 wr+rd is write", l_irq_n, 1'b0);
    drv(0,0,0,0,0,   1,0,1,NXTV,0); chk("R5 right reads left box", l_irq_n, 1'b0);
    drv(1,0,1,NXTV,0, 1,1,0,NXTV,0);chk("R9 set wins left", l_irq_n, 1'b0);
    drv(1,0,1,NXTV,0, 0,0,0,0,0);   chk("R4 left read clears", l_irq_n, 1'b1);
    drv(1,1,0,TOPV,0, 1,0,1,TOPV,0);chk("R9 set wins right", r_irq_n, 1'b0);
    lf = 16'hACE1;
    for (int k = 0; k < 2000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      drv(lf[0], lf[1], lf[2], {2'b11, lf[4:3]} & (lf[5] ? 15 : 12), lf[6] & lf[7],
          lf[8], lf[9], lf[10], {2'b11, lf[12:11]} & (lf[13] ? 15 : 12), lf[14] & lf[15]);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule